// File: doc/BRIEF.md
# ADB request and autopoll controller

This block takes command packets for the desktop input bus as a stream of argument bytes. Each packet either turns into a device request on a bus-side handshake port, or, when it opens with a fixed two-byte key, sets the device mask for periodic autopolling. Replies from the bus side are framed and kept in a small reply store. An ADB-pending flag goes up for the interrupt unit, and that unit later reads the store by address and acknowledges it.

A poll timer runs while the autopoll mask is nonzero. At the end of each period it sends a poll request to the bus side, but only when no reply is waiting and no packet is in progress. A separate strobe switches autopolling off. Signalling on the bus wire belongs to the bus-side agent. That agent takes request bytes with valid/ready and answers with a length header followed by that many data bytes.

Top module: `adb_pkt_ctrl`

## Requirements
- R1: After reset, adb_pend_o, adb_auto_o, reply_len_o, poll_mask_o, busy_o and bus_req_valid_o are all zero.
- R2: A packet with fewer than 2 argument bytes, or with more bytes than the argument store holds, is dropped. It issues no bus request and leaves adb_pend_o clear.
- R3: A packet whose byte 0 is 0x00 and byte 1 is 0x86 is an autopoll setup. With at least 4 bytes it loads poll_mask_o with {byte 2, byte 3}, high byte first. With fewer than 4 bytes it leaves the mask unchanged and issues no bus request.
- R4: A setup carrying the mask already in force has no effect, so the running poll period is not restarted. A new nonzero mask restarts the period, and the first poll request appears POLL_CYCLES cycles after the mask loads.
- R5: A setup with mask 0x0000, or a poll_off_i pulse, clears poll_mask_o, and no further poll requests follow.
- R6: For any other packet, byte 2 is the data length. The packet is dropped when it has fewer than 3 bytes, or when that length exceeds the byte count minus 3 or exceeds MAX_DLEN (252).
- R7: An accepted request goes out as byte count minus 2 beats: byte 0 first, then bytes 3 onward in order, with bus_req_last_o on the final beat and bus_req_poll_o low. A beat holds its data while ready is low.
- R8: A response of length L>0 to a request is stored as reply bytes 0x01, L, then the L data bytes. reply_len_o becomes L+2 and adb_pend_o is raised, with adb_auto_o low.
- R9: A response of length 0 to a request is stored as the single byte 0x00. reply_len_o becomes 1 and adb_pend_o is raised.
- R10: While the mask is nonzero, each period end issues one poll beat (bus_req_poll_o high, bus_req_last_o high). A response of L>0 bytes is stored raw, with reply_len_o = L, and raises both adb_pend_o and adb_auto_o.
- R11: A period that ends while adb_pend_o is set issues no poll request.
- R12: ack_i clears adb_pend_o and adb_auto_o and sets reply_len_o to 0.
- R13: A poll answered with length 0 leaves adb_pend_o, adb_auto_o and reply_len_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arg_valid_i | input | 1 | Argument byte strobe, taken while busy_o is low |
| arg_data_i | input | 8 | Argument byte |
| arg_last_i | input | 1 | Marks the final byte of a packet |
| poll_off_i | input | 1 | Stop autopolling |
| ack_i | input | 1 | Reply consumed; clear the pending flags |
| busy_o | output | 1 | Packet or bus transaction in progress |
| bus_req_valid_o | output | 1 | Request beat valid |
| bus_req_ready_i | input | 1 | Bus side accepts the beat |
| bus_req_data_o | output | 8 | Request byte |
| bus_req_last_o | output | 1 | Final beat of the request |
| bus_req_poll_o | output | 1 | Beat is an autopoll request using poll_mask_o |
| rsp_valid_i | input | 1 | Response header strobe |
| rsp_len_i | input | 8 | Response data length, 0 = no answer |
| rsp_byte_valid_i | input | 1 | Response data byte strobe |
| rsp_byte_i | input | 8 | Response data byte |
| adb_pend_o | output | 1 | Reply waiting |
| adb_auto_o | output | 1 | Waiting reply came from an autopoll |
| reply_len_o | output | 8 | Length of the stored reply |
| rd_addr_i | input | 8 | Reply byte address |
| rd_data_o | output | 8 | Reply byte at rd_addr_i |
| poll_mask_o | output | 16 | Autopoll device mask |

## Verification
The assertions assume a well-behaved bus side. It sends response data bytes only after a header with nonzero length has been taken, one byte per strobe and never in the same cycle as the header, and it sends exactly the announced count, which is at most MAX_RSP. The bench's bus model keeps to this. It drives the header on the cycle after the last request beat is taken, then drives the data bytes on consecutive later cycles. It offers new argument bytes only while busy_o is low and holds ready low for two cycles on each request so that the beat-hold rule is exercised.

// File: rtl/adb_pkt_pkg.sv
package adb_pkt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SEND, ST_POLL, ST_WAIT, ST_RECV
  } ctl_state_e;

  typedef enum logic [1:0] {RM_NONE, RM_NOANS, RM_DATA, RM_RAW} rpl_mode_e;

  localparam logic [7:0] SETUP_KEY0 = 8'h00;
  localparam logic [7:0] SETUP_KEY1 = 8'h86;
  localparam logic [7:0] HDR_DATA   = 8'h01;
  localparam logic [7:0] HDR_NOANS  = 8'h00;
endpackage

// File: rtl/adb_arg_buf.sv
module adb_arg_buf #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [7:0]          wr_data_i,
  input  logic                clr_i,
  input  logic [AW-1:0]       rd_idx_i,
  output logic [7:0]          rd_data_o,
  output logic [3:0][7:0]     head_o,
  output logic [CW-1:0]       cnt_o,
  output logic                ovf_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          ovf_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && cnt_q < CW'(DEPTH)) mem_q[cnt_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_i) begin
      if (cnt_q == CW'(DEPTH)) ovf_q <= 1'b1;
      else                     cnt_q <= cnt_q + CW'(1);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_head
    assign head_o[g] = mem_q[g];
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign cnt_o     = cnt_q;
  assign ovf_o     = ovf_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cnt_q == CW'(DEPTH) |=> ovf_q || clr_i);
endmodule

// File: rtl/adb_poll_timer.sv
module adb_poll_timer #(
  parameter int unsigned PERIOD = 1_500_000,
  localparam int TW = $clog2(PERIOD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  logic [TW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = cnt_q == TW'(PERIOD - 1);
  assign tick_o = run_i && !restart_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (wrap)                cnt_q <= '0;
    else                          cnt_q <= cnt_q + TW'(1);
  end

  // R10
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adb_reply_buf.sv
module adb_reply_buf #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/adb_pkt_ctrl.sv
module adb_pkt_ctrl
  import adb_pkt_pkg::*;
#(
  parameter int          MAX_ARGS    = 16,
  parameter int          MAX_RSP     = 8,
  parameter int          MAX_DLEN    = 252,
  parameter int unsigned POLL_CYCLES = 1_500_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        arg_valid_i,
  input  logic [7:0]  arg_data_i,
  input  logic        arg_last_i,
  input  logic        poll_off_i,
  input  logic        ack_i,
  output logic        busy_o,
  output logic        bus_req_valid_o,
  input  logic        bus_req_ready_i,
  output logic [7:0]  bus_req_data_o,
  output logic        bus_req_last_o,
  output logic        bus_req_poll_o,
  input  logic        rsp_valid_i,
  input  logic [7:0]  rsp_len_i,
  input  logic        rsp_byte_valid_i,
  input  logic [7:0]  rsp_byte_i,
  output logic        adb_pend_o,
  output logic        adb_auto_o,
  output logic [7:0]  reply_len_o,
  input  logic [7:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  output logic [15:0] poll_mask_o
);
  localparam int CW = $clog2(MAX_ARGS + 1);
  localparam int AW = $clog2(MAX_ARGS);
  localparam int RW = $clog2(MAX_RSP);

  ctl_state_e state_q;
  rpl_mode_e  mode_q;
  logic [AW-1:0] send_idx_q;
  logic          is_poll_q;
  logic [7:0]    exp_len_q, rcv_idx_q, reply_len_q;
  logic          pend_q, auto_q;
  logic [15:0]   mask_q;

  // argument store
  logic            arg_wr, arg_clr, arg_ovf;
  logic [AW-1:0]   arg_rd_idx;
  logic [7:0]      arg_rd_data;
  logic [3:0][7:0] head;
  logic [CW-1:0]   arg_cnt;

  assign arg_wr = arg_valid_i && state_q == ST_IDLE;

  adb_arg_buf #(.DEPTH(MAX_ARGS)) u_arg_buf (
    .clk_i, .rst_ni,
    .wr_i(arg_wr), .wr_data_i(arg_data_i), .clr_i(arg_clr),
    .rd_idx_i(arg_rd_idx), .rd_data_o(arg_rd_data),
    .head_o(head), .cnt_o(arg_cnt), .ovf_o(arg_ovf)
  );

  // packet classification
  logic [8:0]  cnt9;
  logic        chk_setup, chk_send, mask_load;
  logic [15:0] new_mask;

  assign cnt9     = 9'(arg_cnt);
  assign new_mask = {head[2], head[3]};

  always_comb begin
    chk_setup = 1'b0;
    chk_send  = 1'b0;
    if (!arg_ovf && arg_cnt >= CW'(2)) begin
      if (head[0] == SETUP_KEY0 && head[1] == SETUP_KEY1)
        chk_setup = arg_cnt >= CW'(4);
      else
        chk_send = arg_cnt >= CW'(3)
                && {1'b0, head[2]} <= cnt9 - 9'd3
                && {1'b0, head[2]} <= 9'(MAX_DLEN);
    end
  end

  assign mask_load = state_q == ST_CHECK && chk_setup && new_mask != mask_q;

  // poll timer
  logic tick, t_restart;
  assign t_restart = mask_load && new_mask != 16'h0;

  adb_poll_timer #(.PERIOD(POLL_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .run_i(mask_q != 16'h0), .restart_i(t_restart), .tick_o(tick)
  );

  // request stream
  logic beat, send_last, poll_go;
  assign beat       = bus_req_valid_o && bus_req_ready_i;
  assign send_last  = 9'(send_idx_q) == cnt9 - 9'd3;
  assign arg_rd_idx = (send_idx_q == '0) ? '0 : send_idx_q + AW'(2);
  assign poll_go    = state_q == ST_IDLE && tick && !pend_q
                   && !arg_valid_i && arg_cnt == '0;
  assign arg_clr    = (state_q == ST_CHECK && !chk_send)
                   || (state_q == ST_SEND && beat && send_last);

  always_comb begin
    bus_req_valid_o = 1'b0;
    bus_req_data_o  = 8'h00;
    bus_req_last_o  = 1'b0;
    bus_req_poll_o  = 1'b0;
    if (state_q == ST_SEND) begin
      bus_req_valid_o = 1'b1;
      bus_req_data_o  = arg_rd_data;
      bus_req_last_o  = send_last;
    end else if (state_q == ST_POLL) begin
      bus_req_valid_o = 1'b1;
      bus_req_last_o  = 1'b1;
      bus_req_poll_o  = 1'b1;
    end
  end

  // response capture
  logic [7:0] len_clip;
  logic       rcv_wr, rcv_done, set_noans;
  assign len_clip  = (rsp_len_i > 8'(MAX_RSP)) ? 8'(MAX_RSP) : rsp_len_i;
  assign rcv_wr    = state_q == ST_RECV && rsp_byte_valid_i;
  assign rcv_done  = rcv_wr && rcv_idx_q == exp_len_q - 8'd1;
  assign set_noans = state_q == ST_WAIT && rsp_valid_i && len_clip == 8'd0 && !is_poll_q;

  logic [RW-1:0] buf_rd_idx;
  logic [7:0]    buf_rd_data;

  adb_reply_buf #(.DEPTH(MAX_RSP)) u_reply_buf (
    .clk_i,
    .wr_i(rcv_wr), .wr_idx_i(RW'(rcv_idx_q)), .wr_data_i(rsp_byte_i),
    .rd_idx_i(buf_rd_idx), .rd_data_o(buf_rd_data)
  );

  always_comb begin
    rd_data_o  = 8'h00;
    buf_rd_idx = '0;
    unique case (mode_q)
      RM_NOANS: rd_data_o = HDR_NOANS;
      RM_DATA: begin
        if (rd_addr_i == 8'd0)      rd_data_o = HDR_DATA;
        else if (rd_addr_i == 8'd1) rd_data_o = reply_len_q - 8'd2;
        else begin
          buf_rd_idx = RW'(rd_addr_i - 8'd2);
          rd_data_o  = buf_rd_data;
        end
      end
      RM_RAW: begin
        buf_rd_idx = RW'(rd_addr_i);
        rd_data_o  = buf_rd_data;
      end
      default: rd_data_o = 8'h00;
    endcase
  end

  // control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= RM_NONE;
      send_idx_q  <= '0;
      is_poll_q   <= 1'b0;
      exp_len_q   <= '0;
      rcv_idx_q   <= '0;
      reply_len_q <= '0;
      pend_q      <= 1'b0;
      auto_q      <= 1'b0;
      mask_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arg_wr && arg_last_i) state_q <= ST_CHECK;
          else if (poll_go)         state_q <= ST_POLL;
        end
        ST_CHECK: begin
          send_idx_q <= '0;
          state_q    <= chk_send ? ST_SEND : ST_IDLE;
        end
        ST_SEND: if (beat) begin
          if (send_last) begin
            state_q   <= ST_WAIT;
            is_poll_q <= 1'b0;
          end else begin
            send_idx_q <= send_idx_q + AW'(1);
          end
        end
        ST_POLL: if (beat) begin
          state_q   <= ST_WAIT;
          is_poll_q <= 1'b1;
        end
        ST_WAIT: if (rsp_valid_i) begin
          if (len_clip == 8'd0) state_q <= ST_IDLE;
          else begin
            exp_len_q <= len_clip;
            rcv_idx_q <= '0;
            state_q   <= ST_RECV;
          end
        end
        ST_RECV: if (rsp_byte_valid_i) begin
          rcv_idx_q <= rcv_idx_q + 8'd1;
          if (rcv_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase

      if (mask_load)                           mask_q <= new_mask;
      else if (poll_off_i && state_q != ST_CHECK) mask_q <= 16'h0;

      if (set_noans) begin
        mode_q      <= RM_NOANS;
        reply_len_q <= 8'd1;
        pend_q      <= 1'b1;
        auto_q      <= 1'b0;
      end else if (rcv_done) begin
        pend_q <= 1'b1;
        if (is_poll_q) begin
          mode_q      <= RM_RAW;
          reply_len_q <= exp_len_q;
          auto_q      <= 1'b1;
        end else begin
          mode_q      <= RM_DATA;
          reply_len_q <= exp_len_q + 8'd2;
          auto_q      <= 1'b0;
        end
      end else if (ack_i) begin
        mode_q      <= RM_NONE;
        reply_len_q <= '0;
        pend_q      <= 1'b0;
        auto_q      <= 1'b0;
      end
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign adb_pend_o  = pend_q;
  assign adb_auto_o  = auto_q;
  assign reply_len_o = reply_len_q;
  assign poll_mask_o = mask_q;

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_o && !bus_req_ready_i |=>
      bus_req_valid_o && $stable(bus_req_data_o) && $stable(bus_req_poll_o));

  // R11
  poll_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_o && bus_req_poll_o |-> !adb_pend_o);

  // R12
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && state_q != ST_WAIT && state_q != ST_RECV |=>
      !adb_pend_o && !adb_auto_o && reply_len_o == 8'd0);

  // R5
  mask_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(poll_mask_o) |-> $past(state_q == ST_CHECK) || $past(poll_off_i));

  // R2
  short_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CHECK && arg_cnt < CW'(2) |=> state_q == ST_IDLE && !bus_req_valid_o);

  // R8
  rsp_in_recv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_byte_valid_i |-> state_q == ST_RECV);
endmodule

// File: tb/adb_pkt_ctrl_bench.sv
`timescale 1ns/1ps
module adb_pkt_ctrl_bench;
  localparam int PER = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        arg_valid = 0, arg_last = 0, poll_off = 0, ack = 0;
  logic [7:0]  arg_data = 0;
  logic        busy, req_valid, req_last, req_poll;
  logic        req_ready = 0;
  logic [7:0]  req_data;
  logic        rsp_valid = 0, rsp_bv = 0;
  logic [7:0]  rsp_len = 0, rsp_byte = 0;
  logic        pend, auto_f;
  logic [7:0]  rlen, rd_addr = 0, rd_data;
  logic [15:0] mask;

  adb_pkt_ctrl #(.MAX_ARGS(16), .MAX_RSP(8), .MAX_DLEN(252), .POLL_CYCLES(PER)) u_adb_pkt_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .arg_valid_i(arg_valid), .arg_data_i(arg_data), .arg_last_i(arg_last),
    .poll_off_i(poll_off), .ack_i(ack), .busy_o(busy),
    .bus_req_valid_o(req_valid), .bus_req_ready_i(req_ready), .bus_req_data_o(req_data),
    .bus_req_last_o(req_last), .bus_req_poll_o(req_poll),
    .rsp_valid_i(rsp_valid), .rsp_len_i(rsp_len), .rsp_byte_valid_i(rsp_bv), .rsp_byte_i(rsp_byte),
    .adb_pend_o(pend), .adb_auto_o(auto_f), .reply_len_o(rlen),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .poll_mask_o(mask)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {n, args (byte k at 8k), rsp count, rsp bytes, request expected, reply length}
  localparam logic [86:0] TBL [8] = '{
    {4'd1, 48'h0000_0000_002C, 2'd0, 24'h000000, 1'b0, 8'd0},
    {4'd2, 48'h0000_0000_002C, 2'd0, 24'h000000, 1'b0, 8'd0},
    {4'd3, 48'h0000_0000_002C, 2'd2, 24'h003412, 1'b1, 8'd4},
    {4'd3, 48'h0000_0001_003C, 2'd0, 24'h000000, 1'b0, 8'd0},
    {4'd5, 48'h005A_A502_002B, 2'd0, 24'h000000, 1'b1, 8'd1},
    {4'd4, 48'h0000_7700_001F, 2'd3, 24'h070809, 1'b1, 8'd5},
    {4'd6, 48'h0302_01FD_002C, 2'd0, 24'h000000, 1'b0, 8'd0},
    {4'd4, 48'h0000_1100_8500, 2'd1, 24'h000042, 1'b1, 8'd3}
  };

  task automatic send_pkt(input int n, input logic [191:0] b);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      arg_valid = 1; arg_data = b[8*k +: 8]; arg_last = (k == n - 1);
    end
    @(negedge clk);
    arg_valid = 0; arg_last = 0;
  endtask

  task automatic collect_req(output int nb, output logic [191:0] got, output bit pol);
    nb = 0; got = '0; pol = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (c >= 2) req_ready = 1;
      if (req_valid && req_ready) begin
        got[8*nb +: 8] = req_data; nb++; pol = req_poll;
        if (req_last) break;
      end
    end
    @(negedge clk);
    req_ready = 0;
  endtask

  task automatic respond(input int rn, input logic [63:0] r);
    rsp_valid = 1; rsp_len = 8'(rn);
    @(negedge clk);
    rsp_valid = 0;
    for (int k = 0; k < rn; k++) begin
      rsp_bv = 1; rsp_byte = r[8*k +: 8];
      @(negedge clk);
    end
    rsp_bv = 0;
  endtask

  task automatic quiet(input int cyc, output bit seen);
    seen = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
  endtask

  task automatic wait_poll(input int max, output bit found, output int cyc);
    found = 0; cyc = max;
    for (int c = 0; c < max; c++) begin
      @(negedge clk);
      req_ready = 1;
      if (req_valid && req_poll) begin found = 1; cyc = c + 1; break; end
    end
    @(negedge clk);
    req_ready = 0;
  endtask

  task automatic do_ack(input string tag);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk({tag, " pend after ack"}, int'(pend), 0);
    chk({tag, " auto after ack"}, int'(auto_f), 0);
    chk({tag, " len after ack"}, int'(rlen), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nb, tot, cyc;
    logic [191:0] got;
    bit pol, seen, found;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 pend", int'(pend), 0);
    chk("R1 auto", int'(auto_f), 0);
    chk("R1 len", int'(rlen), 0);
    chk("R1 mask", int'(mask), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 req", int'(req_valid), 0);

    for (int i = 0; i < 8; i++) begin
      int n, rn;
      logic [47:0] a;
      logic [23:0] r;
      logic [7:0] exp_b [8];
      n = int'(TBL[i][86:83]); a = TBL[i][82:35]; rn = int'(TBL[i][34:33]); r = TBL[i][32:9];
      send_pkt(n, 192'(a));
      if (TBL[i][8]) begin
        collect_req(nb, got, pol);
        chk("R7 beat count", nb, n - 2);
        chk("R7 poll flag", int'(pol), 0);
        for (int k = 0; k < n - 2; k++)
          chk("R7 beat byte", int'(got[8*k +: 8]), int'((k == 0) ? a[7:0] : a[8*(k+2) +: 8]));
        respond(rn, 64'(r));
        chk(rn == 0 ? "R9 pend" : "R8 pend", int'(pend), 1);
        chk("R8 auto low", int'(auto_f), 0);
        chk(rn == 0 ? "R9 len" : "R8 len", int'(rlen), int'(TBL[i][7:0]));
        if (rn == 0) exp_b[0] = 8'h00;
        else begin
          exp_b[0] = 8'h01; exp_b[1] = 8'(rn);
          for (int k = 0; k < rn; k++) exp_b[k+2] = r[8*k +: 8];
        end
        for (int k = 0; k < int'(TBL[i][7:0]); k++) begin
          rd_addr = 8'(k); #1;
          chk(rn == 0 ? "R9 reply byte" : "R8 reply byte", int'(rd_data), int'(exp_b[k]));
        end
        do_ack("R12");
      end else begin
        quiet(8, seen);
        chk(i < 2 ? "R2 no request" : "R6 no request", int'(seen), 0);
        chk(i < 2 ? "R2 pend" : "R6 pend", int'(pend), 0);
        chk(i < 2 ? "R2 busy" : "R6 busy", int'(busy), 0);
      end
    end

    // R2 overflow of the argument store
    send_pkt(17, 192'({17{8'h2C}}));
    quiet(8, seen);
    chk("R2 overlong no request", int'(seen), 0);
    chk("R2 overlong pend", int'(pend), 0);

    // R3 short setup, then valid setup
    send_pkt(3, 192'(24'h12_86_00));
    quiet(8, seen);
    chk("R3 short setup request", int'(seen), 0);
    chk("R3 short setup mask", int'(mask), 0);
    send_pkt(4, 192'(32'h34_12_86_00));
    @(negedge clk);
    chk("R3 mask loaded", int'(mask), 'h1234);

    // R4 same mask mid-period must not restart the period
    quiet(18, seen);
    chk("R4 no early poll", int'(seen), 0);
    send_pkt(4, 192'(32'h34_12_86_00));
    wait_poll(80, found, cyc);
    tot = 2 + 18 + 5 + cyc;
    chk("R4 poll found", int'(found), 1);
    chk("R4 period kept", int'(tot <= PER + 4), 1);

    // R10 poll reply stored raw
    respond(2, 64'hBBAA);
    chk("R10 pend", int'(pend), 1);
    chk("R10 auto", int'(auto_f), 1);
    chk("R10 len", int'(rlen), 2);
    rd_addr = 0; #1; chk("R10 byte0", int'(rd_data), 'hAA);
    rd_addr = 1; #1; chk("R10 byte1", int'(rd_data), 'hBB);

    // R11 no poll while pending
    quiet(3 * PER, seen);
    chk("R11 no poll while pending", int'(seen), 0);
    do_ack("R12 poll");

    // R13 empty poll answer
    wait_poll(2 * PER, found, cyc);
    chk("R10 next poll", int'(found), 1);
    respond(0, 64'h0);
    chk("R13 pend", int'(pend), 0);
    chk("R13 auto", int'(auto_f), 0);
    chk("R13 len", int'(rlen), 0);

    // R5 poll-off strobe
    @(negedge clk); poll_off = 1;
    @(negedge clk); poll_off = 0;
    chk("R5 mask off", int'(mask), 0);
    quiet(3 * PER, seen);
    chk("R5 no poll after off", int'(seen), 0);

    // R5 zero mask via setup
    send_pkt(4, 192'(32'h55_55_86_00));
    @(negedge clk);
    chk("R3 second mask", int'(mask), 'h5555);
    send_pkt(4, 192'(32'h00_00_86_00));
    @(negedge clk);
    chk("R5 zero mask", int'(mask), 0);
    quiet(3 * PER, seen);
    chk("R5 no poll after zero", int'(seen), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule